// File: doc/BRIEF.md
# Dual-Timer PWM Generator

This block produces a pulse-width-modulated level from two down-counters that take turns. One counter times the low part of the waveform and the other times the high part. Only one of them counts at any moment. When the counting timer passes zero, the output level flips and the other timer takes over. The low time and the high time can therefore be set separately, with the full resolution of each counter.

Each timer has a reload latch. A value written to the timer that is counting goes into its latch only, so the phase in progress keeps its length. A value written to the timer that is waiting goes into both the latch and the live count, and it sets the length of that timer's next phase. When a timer passes zero it is reloaded with its latch value minus one. A count-source tick paces both timers. A generator-enable input starts and freezes the sequencing. A separate output-enable input gates the pin without stopping the timers.

Top module: `dual_timer_pwm`

## Requirements
- R1: After reset the pin is low, both live counts are 0, both latches are 0 and the low-phase timer is the one that counts.
- R2: The pin is high only when `pwm_en` is 1, `out_en` is 1 and the generator is in its high phase. With `out_en` at 0 the pin is low and the timers keep counting ticks.
- R3: While `pwm_en` is 1 and the phase is low, each cycle with `tick` at 1 lowers `lo_count` by one and leaves `hi_count` unchanged. In the high phase the roles are swapped.
- R4: A tick that arrives while the low timer is counting and `lo_count` is 0 is an overflow. In the next cycle the phase is high, so the pin is high if enabled, and the high timer counts from then on.
- R5: A tick that arrives while the high timer is counting and `hi_count` is 0 makes the phase low in the next cycle, and the low timer resumes counting.
- R6: A write to the timer that is counting changes only its latch. The live count continues as if no write had happened.
- R7: On overflow a timer's live count is loaded with its latch value minus one, modulo 2^W. The latch value used is the one that includes any write to that timer in the same cycle, so a latch of 0 reloads as all ones.
- R8: A write to a timer that is not counting sets both its latch and its live count. This covers every write while `pwm_en` is 0. A live count V then lasts V+1 ticks.
- R9: With `tick` held at 1 and no writes, every phase after a timer's first reload lasts exactly latch ticks, where a latch of 0 counts as 2^W. With latches 5 and 3 the pin shows low runs of 5 cycles and high runs of 3 cycles.
- R10: While `pwm_en` is 0, neither count moves and the phase is held, whatever `tick` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count-source tick; one count step per cycle when 1 |
| pwm_en | input | 1 | Generator enable; 0 freezes the timers and the phase |
| out_en | input | 1 | Lets the waveform reach the pin |
| lo_wr | input | 1 | Write strobe for the low-phase timer |
| lo_wdata | input | W | Write value for the low-phase timer |
| hi_wr | input | 1 | Write strobe for the high-phase timer |
| hi_wdata | input | W | Write value for the high-phase timer |
| pwm_pin | output | 1 | PWM output level |
| lo_count | output | W | Live count of the low-phase timer |
| hi_count | output | W | Live count of the high-phase timer |

## Verification
The hardest case to reach is a write to a timer in the same cycle that the timer overflows. The reload must then use the new value minus one. That cycle only happens when the write lands on the single tick where the live count is 0, and it matters most with a written value of 0, where the reload wraps to all ones. The random phase keeps most written values below 8, so that overflows are frequent. It also issues a write on about one cycle in eight, which makes these collisions frequent as well, and a bench model predicts every output on every cycle. Directed steps then measure exact run lengths on the pin and catch a deferred write and a reload on the exact overflow cycle.

// File: rtl/dtpwm_pkg.sv
package dtpwm_pkg;
   typedef enum logic {
      PH_LOW  = 1'b0,
      PH_HIGH = 1'b1
   } phase_e;

   localparam int NUM_TIMERS = 2;
   localparam int IDX_LOW    = 0;
   localparam int IDX_HIGH   = 1;
endpackage

// File: rtl/dtpwm_timer.sv
module dtpwm_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         busy,
   input  logic         tick,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] count,
   output logic         ovf
);
   localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
   localparam logic [W-1:0] ZERO = '0;

   logic [W-1:0] latch_q, latch_d;
   logic [W-1:0] cnt_q, cnt_d;

   assign ovf     = busy & tick & (cnt_q == ZERO);
   assign latch_d = wr ? wdata : latch_q;

   always_comb begin
      cnt_d = cnt_q;
      if (ovf)
         cnt_d = latch_d - ONE;
      else if (wr && !busy)
         cnt_d = wdata;
      else if (busy && tick)
         cnt_d = cnt_q - ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
         cnt_q   <= '0;
      end else begin
         latch_q <= latch_d;
         cnt_q   <= cnt_d;
      end
   end

   assign count = cnt_q;

   // R3 / R10: a timer that is not counting and not written holds its count
   a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !wr) |=> (cnt_q == $past(cnt_q)));

   // R3: a counting timer steps down by one on a tick above zero
   a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && tick && cnt_q != ZERO) |=> (cnt_q == $past(cnt_q) - ONE));

   // R6: a write to the counting timer leaves the live count alone
   a_r6_deferred_write: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr && !tick) |=> (cnt_q == $past(cnt_q)));

   // R7: after overflow the count sits one below the latch
   a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> (cnt_q == latch_q - ONE));

   // R8: a write to a waiting timer lands in the count and the latch
   a_r8_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !busy) |=> (cnt_q == latch_q));
endmodule

// File: rtl/dtpwm_seq.sv
module dtpwm_seq
   import dtpwm_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  en,
   input  logic [NUM_TIMERS-1:0] ovf,
   output logic [NUM_TIMERS-1:0] busy,
   output phase_e                phase
);
   phase_e phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase_q <= PH_LOW;
      else if (en && (ovf != '0))
         phase_q <= (phase_q == PH_LOW) ? PH_HIGH : PH_LOW;
   end

   assign busy[IDX_LOW]  = en & (phase_q == PH_LOW);
   assign busy[IDX_HIGH] = en & (phase_q == PH_HIGH);
   assign phase          = phase_q;

   // R4 / R5: the two timers never pass zero in the same cycle
   a_r4_single_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ovf));

   // R4 / R5: an overflow flips the phase
   a_r5_flip: assert property (@(posedge clk) disable iff (!rst_n)
      (en && ovf != '0) |=> (phase_q != $past(phase_q)));

   // R10: a disabled generator keeps its phase
   a_r10_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(phase_q));
endmodule

// File: rtl/dual_timer_pwm.sv
module dual_timer_pwm
   import dtpwm_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         pwm_en,
   input  logic         out_en,
   input  logic         lo_wr,
   input  logic [W-1:0] lo_wdata,
   input  logic         hi_wr,
   input  logic [W-1:0] hi_wdata,
   output logic         pwm_pin,
   output logic [W-1:0] lo_count,
   output logic [W-1:0] hi_count
);
   generate
      if (W < 2 || W > 32) begin : g_bad_width
         $error("dual_timer_pwm: W must lie in 2..32");
      end
   endgenerate

   logic [NUM_TIMERS-1:0]        wr_v;
   logic [NUM_TIMERS-1:0][W-1:0] wd_v;
   logic [NUM_TIMERS-1:0][W-1:0] cnt_v;
   logic [NUM_TIMERS-1:0]        ovf_v;
   logic [NUM_TIMERS-1:0]        busy_v;
   phase_e                       phase;

   assign wr_v[IDX_LOW]  = lo_wr;
   assign wr_v[IDX_HIGH] = hi_wr;
   assign wd_v[IDX_LOW]  = lo_wdata;
   assign wd_v[IDX_HIGH] = hi_wdata;

   for (genvar gi = 0; gi < NUM_TIMERS; gi++) begin : g_timer
      dtpwm_timer #(.W(W)) u_timer (
         .clk   (clk),
         .rst_n (rst_n),
         .busy  (busy_v[gi]),
         .tick  (tick),
         .wr    (wr_v[gi]),
         .wdata (wd_v[gi]),
         .count (cnt_v[gi]),
         .ovf   (ovf_v[gi])
      );
   end

   dtpwm_seq u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (pwm_en),
      .ovf   (ovf_v),
      .busy  (busy_v),
      .phase (phase)
   );

   assign pwm_pin  = pwm_en & out_en & (phase == PH_HIGH);
   assign lo_count = cnt_v[IDX_LOW];
   assign hi_count = cnt_v[IDX_HIGH];

   // R1: the low timer counts first after reset
   a_r1_low_first: assert property (@(posedge clk)
      $rose(rst_n) |-> (phase == PH_LOW));

   // R2: the pin is driven by the high phase only
   a_r2_pin_high_phase: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_pin |-> busy_v[IDX_HIGH]);
endmodule

// File: tb/dual_timer_pwm_bench.sv
module dual_timer_pwm_bench;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tick = 1'b0, pwm_en = 1'b0, out_en = 1'b0;
   logic         lo_wr = 1'b0, hi_wr = 1'b0;
   logic [W-1:0] lo_wdata = '0, hi_wdata = '0;
   logic         pwm_pin;
   logic [W-1:0] lo_count, hi_count;

   always #4 clk = ~clk;

   dual_timer_pwm #(.W(W)) u_dual_timer_pwm (
      .clk(clk), .rst_n(rst_n), .tick(tick), .pwm_en(pwm_en), .out_en(out_en),
      .lo_wr(lo_wr), .lo_wdata(lo_wdata), .hi_wr(hi_wr), .hi_wdata(hi_wdata),
      .pwm_pin(pwm_pin), .lo_count(lo_count), .hi_count(hi_count)
   );

   int n_chk = 0, n_bad = 0, cyc = 0;
   bit finished = 1'b0;

   // reference state derived from the requirements
   logic         m_hi;
   logic [W-1:0] m_cnt [2];
   logic [W-1:0] m_lat [2];

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic logic [W-1:0] next_cnt(input logic bsy, input logic t,
         input logic w, input logic [W-1:0] d, input logic [W-1:0] c,
         input logic [W-1:0] l);
      logic [W-1:0] ln;
      ln = w ? d : l;
      if (bsy && t && c == '0) return ln - 1'b1;   // R7
      if (w && !bsy)           return d;           // R8
      if (bsy && t)            return c - 1'b1;    // R3
      return c;                                    // R6 / R10
   endfunction

   task automatic step(input logic t, input logic w0, input logic [W-1:0] d0,
                       input logic w1, input logic [W-1:0] d1);
      logic b0, b1, o0, o1;
      tick = t; lo_wr = w0; lo_wdata = d0; hi_wr = w1; hi_wdata = d1;
      b0 = pwm_en && !m_hi;
      b1 = pwm_en && m_hi;
      o0 = b0 && t && m_cnt[0] == '0;
      o1 = b1 && t && m_cnt[1] == '0;
      m_cnt[0] = next_cnt(b0, t, w0, d0, m_cnt[0], m_lat[0]);
      m_cnt[1] = next_cnt(b1, t, w1, d1, m_cnt[1], m_lat[1]);
      if (w0) m_lat[0] = d0;
      if (w1) m_lat[1] = d1;
      if (o0 || o1) m_hi = ~m_hi;
      @(posedge clk);
      @(negedge clk);
      lo_wr = 1'b0; hi_wr = 1'b0;
      check("MODEL pin", int'(pwm_pin), int'(pwm_en && out_en && m_hi));
      check("MODEL lo_count", int'(lo_count), int'(m_cnt[0]));
      check("MODEL hi_count", int'(hi_count), int'(m_cnt[1]));
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) step(1'b1, 1'b0, '0, 1'b0, '0);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000 && !finished) begin
         finished = 1'b1;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 50000);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int rl [8];
      int nrun, len, guard;
      logic prev;
      logic [W-1:0] plo, phi;
      void'($urandom(32'd20240611));
      m_hi = 1'b0; m_cnt[0] = '0; m_cnt[1] = '0; m_lat[0] = '0; m_lat[1] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1 pin", int'(pwm_pin), 0);
      check("R1 lo_count", int'(lo_count), 0);
      check("R1 hi_count", int'(hi_count), 0);

      // R8: writes while disabled load count and latch
      step(1'b0, 1'b1, 8'd5, 1'b1, 8'd3);
      check("R8 lo_count", int'(lo_count), 5);
      check("R8 hi_count", int'(hi_count), 3);

      // R10: ticks while disabled move nothing
      run(3);
      check("R10 lo_count", int'(lo_count), 5);
      check("R10 hi_count", int'(hi_count), 3);

      // R3: enabled low phase steps the low timer only
      pwm_en = 1'b1; out_en = 1'b1;
      run(1);
      check("R3 lo_count", int'(lo_count), 4);
      check("R3 hi_count", int'(hi_count), 3);
      check("R3 pin", int'(pwm_pin), 0);

      // R9 / R8: run lengths on the pin with a steady tick
      nrun = 0; len = 1; prev = pwm_pin;
      for (int i = 0; i < 30; i++) begin
         run(1);
         if (pwm_pin == prev) len++;
         else begin
            if (nrun < 8) rl[nrun] = len;
            nrun++; len = 1; prev = pwm_pin;
         end
      end
      check("R8 first high run", rl[1], 4);
      check("R9 steady low run", rl[2], 5);
      check("R9 steady high run", rl[3], 3);

      // R6: write to the counting low timer goes to its latch only
      guard = 0;
      while (!(pwm_pin == 1'b0 && lo_count >= 2) && guard < 600) begin run(1); guard++; end
      plo = lo_count; phi = hi_count;
      step(1'b1, 1'b1, 8'd9, 1'b0, '0);
      check("R6 lo_count", int'(lo_count), int'(plo) - 1);
      check("R6 hi_count", int'(hi_count), int'(phi));

      // R7 / R4: overflow reloads latch minus one and raises the pin
      guard = 0;
      while (lo_count != '0 && guard < 600) begin run(1); guard++; end
      run(1);
      check("R7 lo reload", int'(lo_count), 8);
      check("R4 pin high", int'(pwm_pin), 1);

      // R5 / R7: high timer overflow lowers the pin
      guard = 0;
      while (hi_count != '0 && guard < 600) begin run(1); guard++; end
      run(1);
      check("R5 pin low", int'(pwm_pin), 0);
      check("R7 hi reload", int'(hi_count), 2);

      // R2: output gated off while timers run
      out_en = 1'b0;
      plo = lo_count;
      for (int i = 0; i < 4; i++) begin
         run(1);
         check("R2 pin gated", int'(pwm_pin), 0);
      end
      check("R2 timers still run", int'(lo_count != plo), 1);
      out_en = 1'b1;

      // random phase: small values so overflows and collisions are frequent
      for (int i = 0; i < 4000; i++) begin
         logic [W-1:0] d0, d1;
         if ($urandom % 50 == 0) pwm_en = ~pwm_en;
         if ($urandom % 40 == 0) out_en = ~out_en;
         d0 = ($urandom % 6 == 0) ? W'($urandom) : W'($urandom % 8);
         d1 = ($urandom % 6 == 0) ? W'($urandom) : W'($urandom % 8);
         step(W'($urandom % 4) != 0, ($urandom % 8) == 0, d0, ($urandom % 8) == 0, d1);
      end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule